// File: doc/BRIEF.md
# Vertical Countdown Divider with Acceptance Windows

This block derives the vertical drive pulse of a television timing chain from a half-line timing tick and a separated vertical sync strobe. A counter tracks position within the current field in half-line units, so both interlaced fields land on the same counts: 625 half-lines for a 50 Hz field, 525 for a 60 Hz field. A vertical sync strobe restarts the counter only when it arrives inside the acceptance window of the current mode. When no sync arrives, the counter restarts by itself at the window's end, so the drive pulse keeps coming.

There are three modes. Search takes any sync in a wide range. Narrow takes a sync only within a few half-lines of the expected field length. Norm divides by exactly the standard field length and uses sync only as a confirmation. Runs of hits move the block toward norm, and runs of misses move it back. A lost horizontal lock or an explicit force-search request drops it straight to search, which speeds up recovery after a channel change. A two-bit control picks how the 50/60 Hz standard is chosen. Every input is a plain level or a one-clock strobe sampled on the clock. There is no stream interface, so there is no back-pressure.

Top module: `vsync_divider`

## Requirements
- R1: After reset the mode output is search (mode encoding: 0 search, 1 narrow, 2 norm), `vpulse` is low and `std50` is 0 (the standard flag reads 1 for 50 Hz and 0 for 60 Hz).
- R2: In search mode a sync strobe restarts the field counter when the count is between 488 and 722 inclusive, and is ignored otherwise. With no accepted sync, the counter restarts on its own at count 723.
- R3: `vpulse` goes high in the clock after any restart and stays high for 8 ticks.
- R4: Search becomes narrow on the 16th consecutive accepted sync that lies within 3 of 625 or within 3 of 525. An accepted sync outside both of those ranges, or a restart on its own, clears the run.
- R5: In narrow mode the window is the expected length E ±3 (E is 625 when `std50` is 1, otherwise 525). A sync inside the window restarts the counter, a sync outside it is ignored, and with no sync the restart comes at count E+4.
- R6: Narrow returns to search after 6 successive restarts that came on their own. If narrow was entered from norm, 3 such restarts are enough.
- R7: Narrow becomes norm on the 15th consecutive sync that arrives exactly at count E.
- R8: Norm restarts at exactly count E whether or not sync is present, and a sync never restarts it. A field counts as a hit when sync arrived at counts E-3 to E. Three successive missed fields return the block to narrow.
- R9: While `hlock` is low or `force_search` is high, the mode is search from the next clock on, and all run counters are cleared.
- R10: `ffreq` selects the standard. 0 detects it automatically and sets 60 Hz when unlocked. 1 forces 60 Hz from the next clock on. 2 holds the current value. 3 detects it automatically and sets 50 Hz when unlocked. Detection sets `std50` from which norm range an accepted sync lay in.
- R11: The field counter and the pulse length advance only on clocks with `line_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | Half-line timing strobe |
| vsync | input | 1 | Separated vertical sync strobe, one clock |
| hlock | input | 1 | Horizontal loop locked |
| force_search | input | 1 | Force the search window |
| ffreq | input | 2 | Field-frequency selection code |
| vpulse | output | 1 | Vertical drive pulse |
| mode | output | 2 | Current window mode |
| std50 | output | 1 | Detected standard, 1 = 50 Hz |

## Verification
The hardest state to reach is narrow mode entered from norm, where the miss limit shrinks from 6 to 3. To get there, the stimulus first needs 16 in-range syncs, then 15 syncs placed exactly on the norm count, then 3 norm fields without sync. The bench tracks the counter position from the half-line count since each restart it has seen. This lets it place every sync on an exact count, and it then measures the flywheel periods in each mode against the window limits. Randomly placed syncs inside the search range, kept away from both norm ranges, check that the run counter does not advance while restarts still happen.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic [1:0] {
    VM_SEARCH = 2'd0,
    VM_NARROW = 2'd1,
    VM_NORM   = 2'd2
  } vmode_e;

  typedef enum logic [1:0] {
    FF_AUTO60  = 2'd0,
    FF_FORCE60 = 2'd1,
    FF_HOLD    = 2'd2,
    FF_AUTO50  = 2'd3
  } ffreq_e;
endpackage

// File: rtl/vdiv_linecnt.sv
module vdiv_linecnt #(
  parameter int CW        = 10,
  parameter int CNT_MAX   = 723,
  parameter int PULSE_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic          vpulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] CMAX = CW'(CNT_MAX);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      if (restart)
        cnt <= '0;
      else if (tick && cnt != CMAX)
        cnt <= cnt + 1'b1;

      if (restart)
        pcnt <= PW'(PULSE_LEN);
      else if (tick && pcnt != '0)
        pcnt <= pcnt - 1'b1;
    end
  end

  assign vpulse = (pcnt != '0);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);

  // R3
  pulse_after_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpulse) |-> $past(restart));

  // R2
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && vpulse);

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/vdiv_window.sv
module vdiv_window
  import vdiv_pkg::*;
#(
  parameter int CW      = 10,
  parameter int SRCH_LO = 488,
  parameter int SRCH_HI = 722,
  parameter int HL50    = 625,
  parameter int HL60    = 525,
  parameter int NWIN    = 3
) (
  input  logic [CW-1:0] cnt,
  input  logic          std50,
  input  vmode_e        mode,
  output logic          in_search,
  output logic          near50,
  output logic          near60,
  output logic          in_narrow,
  output logic          on_norm,
  output logic          pre_norm,
  output logic          limit_hit
);
  localparam logic [CW-1:0] S_LO   = CW'(SRCH_LO);
  localparam logic [CW-1:0] S_HI   = CW'(SRCH_HI);
  localparam logic [CW-1:0] S_LIM  = CW'(SRCH_HI + 1);
  localparam logic [CW-1:0] N50_LO = CW'(HL50 - NWIN);
  localparam logic [CW-1:0] N50_HI = CW'(HL50 + NWIN);
  localparam logic [CW-1:0] N60_LO = CW'(HL60 - NWIN);
  localparam logic [CW-1:0] N60_HI = CW'(HL60 + NWIN);
  localparam logic [CW-1:0] W      = CW'(NWIN);

  logic [CW-1:0] expct;
  logic [CW-1:0] limit;

  assign expct     = std50 ? CW'(HL50) : CW'(HL60);
  assign in_search = (cnt >= S_LO) && (cnt <= S_HI);
  assign near50    = (cnt >= N50_LO) && (cnt <= N50_HI);
  assign near60    = (cnt >= N60_LO) && (cnt <= N60_HI);
  assign in_narrow = (cnt >= expct - W) && (cnt <= expct + W);
  assign on_norm   = (cnt == expct);
  assign pre_norm  = (cnt >= expct - W) && (cnt < expct);

  always_comb begin
    case (mode)
      VM_NARROW: limit = expct + W + 1'b1;
      VM_NORM:   limit = expct;
      default:   limit = S_LIM;
    endcase
  end

  assign limit_hit = (cnt >= limit);
endmodule

// File: rtl/vdiv_mode.sv
module vdiv_mode
  import vdiv_pkg::*;
#(
  parameter int SEARCH_HITS = 16,
  parameter int NORM_HITS   = 15,
  parameter int NARROW_MISS = 6,
  parameter int NORM_MISS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync,
  input  logic       hlock,
  input  logic       force_search,
  input  logic [1:0] ffreq,
  input  logic       in_search,
  input  logic       near50,
  input  logic       near60,
  input  logic       in_narrow,
  input  logic       on_norm,
  input  logic       pre_norm,
  input  logic       limit_hit,
  output vmode_e     mode,
  output logic       std50,
  output logic       restart
);
  localparam int HW     = $clog2(SEARCH_HITS + 1);
  localparam int NW     = $clog2(NORM_HITS + 1);
  localparam int MMAX   = (NARROW_MISS > NORM_MISS) ? NARROW_MISS : NORM_MISS;
  localparam int MW     = $clog2(MMAX + 1);

  logic [HW-1:0] hits;
  logic [NW-1:0] nhits;
  logic [MW-1:0] miss;
  logic          seen;
  logic          from_norm;
  logic          relock;
  logic          acc_sync;
  logic [MW-1:0] mlast;
  ffreq_e        fsel;

  assign fsel   = ffreq_e'(ffreq);
  assign relock = force_search || !hlock;
  assign mlast  = from_norm ? MW'(NORM_MISS - 1) : MW'(NARROW_MISS - 1);

  always_comb begin
    case (mode)
      VM_SEARCH: acc_sync = vsync && in_search;
      VM_NARROW: acc_sync = vsync && in_narrow;
      default:   acc_sync = 1'b0;
    endcase
  end

  assign restart = acc_sync || limit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std50 <= 1'b0;
    end else if (fsel == FF_FORCE60) begin
      std50 <= 1'b0;
    end else if (fsel != FF_HOLD) begin
      if (!hlock)
        std50 <= (fsel == FF_AUTO50);
      else if (acc_sync && near50)
        std50 <= 1'b1;
      else if (acc_sync && near60)
        std50 <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || relock) begin
      mode      <= VM_SEARCH;
      hits      <= '0;
      nhits     <= '0;
      miss      <= '0;
      seen      <= 1'b0;
      from_norm <= 1'b0;
    end else begin
      case (mode)
        VM_SEARCH: begin
          if (acc_sync) begin
            if (near50 || near60) begin
              if (hits == HW'(SEARCH_HITS - 1)) begin
                mode <= VM_NARROW;
                hits <= '0;
              end else begin
                hits <= hits + 1'b1;
              end
            end else begin
              hits <= '0;
            end
          end else if (limit_hit) begin
            hits <= '0;
          end
        end
        VM_NARROW: begin
          if (acc_sync) begin
            miss <= '0;
            if (on_norm) begin
              if (nhits == NW'(NORM_HITS - 1)) begin
                mode      <= VM_NORM;
                nhits     <= '0;
                from_norm <= 1'b0;
              end else begin
                nhits <= nhits + 1'b1;
              end
            end else begin
              nhits <= '0;
            end
          end else if (limit_hit) begin
            nhits <= '0;
            if (miss == mlast) begin
              mode      <= VM_SEARCH;
              miss      <= '0;
              from_norm <= 1'b0;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
        default: begin
          if (limit_hit) begin
            seen <= 1'b0;
            if (seen || vsync) begin
              miss <= '0;
            end else if (miss == MW'(NORM_MISS - 1)) begin
              mode      <= VM_NARROW;
              miss      <= '0;
              from_norm <= 1'b1;
            end else begin
              miss <= miss + 1'b1;
            end
          end else if (vsync && pre_norm) begin
            seen <= 1'b1;
          end
        end
      endcase
    end
  end

  // R9
  search_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlock || force_search) |=> mode == VM_SEARCH);

  // R10
  force60_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffreq == 2'd1) |=> !std50);

  // R10
  hold_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffreq == 2'd2) |=> $stable(std50));

  // R7
  no_skip_to_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == VM_NORM) |-> $past(mode) != VM_SEARCH);

  // R8
  norm_no_sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == VM_NORM && restart) |-> limit_hit);

  // R1
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

// File: rtl/vsync_divider.sv
module vsync_divider
  import vdiv_pkg::*;
#(
  parameter int SRCH_LO     = 488,
  parameter int SRCH_HI     = 722,
  parameter int HL50        = 625,
  parameter int HL60        = 525,
  parameter int NWIN        = 3,
  parameter int PULSE_LEN   = 8,
  parameter int SEARCH_HITS = 16,
  parameter int NORM_HITS   = 15,
  parameter int NARROW_MISS = 6,
  parameter int NORM_MISS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       vsync,
  input  logic       hlock,
  input  logic       force_search,
  input  logic [1:0] ffreq,
  output logic       vpulse,
  output logic [1:0] mode,
  output logic       std50
);
  localparam int CNT_MAX = SRCH_HI + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt;
  logic          restart;
  logic          in_search, near50, near60, in_narrow, on_norm, pre_norm, limit_hit;
  vmode_e        mode_q;

  vdiv_linecnt #(
    .CW(CW), .CNT_MAX(CNT_MAX), .PULSE_LEN(PULSE_LEN)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .restart(restart),
    .cnt(cnt), .vpulse(vpulse)
  );

  vdiv_window #(
    .CW(CW), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
    .HL50(HL50), .HL60(HL60), .NWIN(NWIN)
  ) u_win (
    .cnt(cnt), .std50(std50), .mode(mode_q),
    .in_search(in_search), .near50(near50), .near60(near60),
    .in_narrow(in_narrow), .on_norm(on_norm), .pre_norm(pre_norm),
    .limit_hit(limit_hit)
  );

  vdiv_mode #(
    .SEARCH_HITS(SEARCH_HITS), .NORM_HITS(NORM_HITS),
    .NARROW_MISS(NARROW_MISS), .NORM_MISS(NORM_MISS)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hlock(hlock),
    .force_search(force_search), .ffreq(ffreq),
    .in_search(in_search), .near50(near50), .near60(near60),
    .in_narrow(in_narrow), .on_norm(on_norm), .pre_norm(pre_norm),
    .limit_hit(limit_hit),
    .mode(mode_q), .std50(std50), .restart(restart)
  );

  assign mode = mode_q;
endmodule

// File: tb/vsync_divider_tb.sv
module vsync_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_SRCH   = 723;
  localparam int LIM_NAR50  = 629;
  localparam int NORM50     = 625;
  localparam int NORM60     = 525;
  localparam int PULSE      = 8;

  logic clk = 1'b0, rst_n = 1'b0, line_tick = 1'b1, vsync = 1'b0;
  logic hlock = 1'b0, force_search = 1'b0;
  logic [1:0] ffreq = 2'd0;
  logic vpulse, std50;
  logic [1:0] mode;

  int n_tests = 0, n_fail = 0, pos = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_divider u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync),
    .hlock(hlock), .force_search(force_search), .ffreq(ffreq),
    .vpulse(vpulse), .mode(mode), .std50(std50)
  );

  task automatic check_eq(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gap_to(int lim, int from);
    return lim - from;
  endfunction

  function automatic bit near_norm(int p);
    return (p >= NORM60 - 3 && p <= NORM60 + 3) || (p >= NORM50 - 3 && p <= NORM50 + 3);
  endfunction

  task automatic step();
    @(negedge clk);
    pos++;
  endtask

  task automatic send_at(int p, bit rs);
    while (pos < p - 1) step();
    vsync = 1'b1;
    step();
    vsync = 1'b0;
    if (rs) pos = -1;
  endtask

  task automatic measure(output int n);
    bit last;
    n = 0;
    last = vpulse;
    while (n < 3000) begin
      step();
      n++;
      if (vpulse && !last) break;
      last = vpulse;
    end
    pos = -1;
  endtask

  task automatic fields(int k, int p);
    for (int i = 0; i < k; i++) send_at(p, 1'b1);
  endtask

  task automatic flywheel(string tag, int lim);
    int e, n;
    e = gap_to(lim, pos);
    measure(n);
    check_eq(tag, n, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w, p;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pos = -1;
    check_eq("R1 mode after reset", mode, 0);
    check_eq("R1 vpulse after reset", vpulse, 0);
    check_eq("R1 std after reset", std50, 0);
    hlock = 1'b1;

    // R11: ten clocks without tick must not advance the counter
    line_tick = 1'b0;
    repeat (10) @(negedge clk);
    line_tick = 1'b1;
    flywheel("R11 search flywheel after tick gap", LIM_SRCH);
    // R3 pulse width
    w = 0;
    while (vpulse && w < 100) begin step(); w++; end
    check_eq("R3 pulse width", w, PULSE);

    // R4 search to narrow
    fields(15, NORM50);
    check_eq("R4 still search after 15", mode, 0);
    fields(1, NORM50);
    check_eq("R4 narrow after 16", mode, 1);
    check_eq("R10 auto detect 50", std50, 1);

    // R5 narrow window
    send_at(300, 1'b0);
    check_eq("R5 early sync ignored", vpulse, 0);
    flywheel("R5 narrow end-of-window restart", LIM_NAR50);
    send_at(NORM50 - 1, 1'b1);
    check_eq("R5 in-window restart", vpulse, 1);
    fields(14, NORM50);
    check_eq("R7 narrow after 14 norm hits", mode, 1);
    fields(1, NORM50);
    check_eq("R7 norm after 15", mode, 2);

    // R8 norm behaviour
    fields(1, NORM50);
    check_eq("R8 norm hit keeps norm", mode, 2);
    send_at(400, 1'b0);
    check_eq("R8 off-time sync no restart", vpulse, 0);
    flywheel("R8 norm restart at count", NORM50);
    flywheel("R8 norm miss 2 period", NORM50);
    check_eq("R8 norm after 2 misses", mode, 2);
    flywheel("R8 norm miss 3 period", NORM50);
    check_eq("R8 narrow after 3 misses", mode, 1);

    // R6 narrow from norm: 3 misses
    flywheel("R6 narrow miss period", LIM_NAR50);
    flywheel("R6 narrow miss period", LIM_NAR50);
    check_eq("R6 still narrow after 2", mode, 1);
    flywheel("R6 narrow miss period", LIM_NAR50);
    check_eq("R6 search after 3 from norm", mode, 0);

    // R4 run cleared by a non-norm accepted sync
    fields(15, NORM50);
    send_at(560, 1'b1);
    fields(15, NORM50);
    check_eq("R4 run cleared", mode, 0);
    fields(1, NORM50);
    check_eq("R4 narrow after fresh 16", mode, 1);

    // R6 fresh narrow: 6 misses
    for (int i = 0; i < 5; i++) flywheel("R6 narrow miss period", LIM_NAR50);
    check_eq("R6 narrow after 5 misses", mode, 1);
    flywheel("R6 narrow miss period", LIM_NAR50);
    check_eq("R6 search after 6 misses", mode, 0);

    // R2 search acceptance bounds
    send_at(300, 1'b0);
    check_eq("R2 sync below window ignored", vpulse, 0);
    flywheel("R2 search flywheel", LIM_SRCH);
    send_at(487, 1'b0);
    check_eq("R2 sync at 487 ignored", vpulse, 0);
    flywheel("R2 search flywheel", LIM_SRCH);
    send_at(488, 1'b1);
    check_eq("R2 sync at 488 accepted", vpulse, 1);
    send_at(722, 1'b1);
    check_eq("R2 sync at 722 accepted", vpulse, 1);

    // R2 random syncs away from norm ranges
    for (int i = 0; i < 40; i++) begin
      do p = 488 + int'($urandom_range(0, 234)); while (near_norm(p));
      send_at(p, 1'b1);
      check_eq("R2 random accepted sync", vpulse, 1);
      check_eq("R4 random keeps search", mode, 0);
    end

    // R9 force search
    fields(16, NORM50);
    check_eq("R9 narrow before force", mode, 1);
    force_search = 1'b1;
    step();
    force_search = 1'b0;
    check_eq("R9 force search", mode, 0);

    // R9 / R10 unlock behaviour
    ffreq = 2'd3;
    hlock = 1'b0;
    step();
    check_eq("R9 search when unlocked", mode, 0);
    check_eq("R10 auto50 unlocked", std50, 1);
    ffreq = 2'd0;
    step();
    check_eq("R10 auto60 unlocked", std50, 0);
    hlock = 1'b1;
    send_at(NORM50, 1'b1);
    check_eq("R10 detect 50", std50, 1);
    ffreq = 2'd1;
    step();
    check_eq("R10 force60 immediate", std50, 0);
    send_at(NORM50, 1'b1);
    check_eq("R10 force60 ignores detection", std50, 0);
    ffreq = 2'd0;
    send_at(NORM50, 1'b1);
    check_eq("R10 detect 50 again", std50, 1);
    ffreq = 2'd2;
    send_at(NORM60, 1'b1);
    check_eq("R10 hold ignores 60 sync", std50, 1);
    hlock = 1'b0;
    step();
    check_eq("R10 hold while unlocked", std50, 1);
    hlock = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule